// File: doc/BRIEF.md
# Integer Arithmetic and Compare Unit

This block is the arithmetic core of a single-cycle processor's execute stage. It is purely combinational: two operands and a four-bit operation selector go in, and in the same cycle a result word, a zero indication and a signed-overflow indication come out. The same unit computes register-to-register arithmetic and logic. It forms load and store addresses by adding a base register to an offset that has already been sign-extended. It also decides branch-on-equal by subtracting the two operands and reading the zero indication.

The operand width is a parameter (default 32). Both operands and the result have that width. There is no clock, no handshake and no internal state, because the processor consumes the result within the same cycle. Selector codes that name no operation yield an all-zero result.

Top module: `alu_core`

## Requirements
- R1: Selector code 0 (add) produces `opnd_a + opnd_b` modulo 2^W, where W is the operand width. This covers address formation from a base and a sign-extended offset.
- R2: Selector code 1 (subtract) produces `opnd_a - opnd_b` modulo 2^W.
- R3: Selector codes 2, 3, 4 and 5 produce the bitwise AND, OR, XOR and NOR of the operands, in that order.
- R4: Selector code 6 (signed less-than) produces 1 when `opnd_a` is less than `opnd_b` as two's-complement values and 0 otherwise. The bit sits in position 0 and all upper bits are 0. The answer is correct even when the internal difference overflows.
- R5: Selector code 7 (unsigned less-than) produces 1 when `opnd_a` is less than `opnd_b` as unsigned values and 0 otherwise, with all upper bits 0.
- R6: `zero_flag` is 1 exactly when every bit of `result` is 0, for every selector code. After a subtract, this flag equals the equality of the operands.
- R7: `ovf_flag` is 1 only for add and subtract, and only when the true signed result does not fit in W bits. It is 0 for codes 2 through 15.
- R8: Selector codes 8 through 15 produce a `result` of 0, a `zero_flag` of 1 and an `ovf_flag` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand (minuend for subtract and compares) |
| opnd_b | input | W | Second operand |
| op_sel | input | 4 | Operation selector, codes 0 to 7 defined |
| result | output | W | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
A 4-bit instance is swept over every combination of both operands and all sixteen selector codes. This reaches every carry, borrow and signed-overflow case. It also covers the operand pairs whose sign bits differ, which separate a correct signed compare from one that only reads the sign of the difference. A 32-bit instance is tried with corner patterns: extreme positive and negative values, equal operands, all-ones and zero, and a base plus negative offset. These confirm that the width parameter carries through the carry chain and the compare logic. Undefined selector codes are swept with nonzero operands, so that any leakage of an internal result shows up at the ports.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOR  = 4'd5,
    OP_SLT  = 4'd6,
    OP_SLTU = 4'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = do_sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
  assign sum       = wide[W-1:0];
  assign carry_out = wide[W];
  // like-signed inputs whose sum flips sign
  assign ovf = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0]              a,
  input  logic [W-1:0]              b,
  input  alu_core_pkg::logic_sel_e  sel,
  output logic [W-1:0]              y
);
  import alu_core_pkg::*;

  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_compare.sv
module alu_compare (
  input  logic a_msb,
  input  logic b_msb,
  input  logic diff_msb,
  input  logic carry_out,
  output logic lt_signed,
  output logic lt_unsigned
);
  // differing signs: A is lower exactly when A is negative,
  // otherwise the difference cannot overflow and its sign decides
  assign lt_signed   = (a_msb ^ b_msb) ? a_msb : diff_msb;
  // A - B computed as A + ~B + 1: no carry out means a borrow
  assign lt_unsigned = ~carry_out;
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 32
) (
  input  logic [W-1:0]                 opnd_a,
  input  logic [W-1:0]                 opnd_b,
  input  logic [alu_core_pkg::OP_W-1:0] op_sel,
  output logic [W-1:0]                 result,
  output logic                         zero_flag,
  output logic                         ovf_flag
);
  import alu_core_pkg::*;

  localparam int UPPER_W = W - 1;

  logic [W-1:0] arith_sum;
  logic         arith_carry;
  logic         arith_ovf;
  logic         arith_sub;
  logic [W-1:0] logic_y;
  logic_sel_e   logic_sel;
  logic         lt_s;
  logic         lt_u;
  logic         is_arith;

  assign arith_sub = (op_sel == OP_SUB) || (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign is_arith  = (op_sel == OP_ADD) || (op_sel == OP_SUB);

  always_comb begin
    unique case (op_sel)
      OP_OR:   logic_sel = LG_OR;
      OP_XOR:  logic_sel = LG_XOR;
      OP_NOR:  logic_sel = LG_NOR;
      default: logic_sel = LG_AND;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a        (opnd_a),
    .b        (opnd_b),
    .do_sub   (arith_sub),
    .sum      (arith_sum),
    .carry_out(arith_carry),
    .ovf      (arith_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a  (opnd_a),
    .b  (opnd_b),
    .sel(logic_sel),
    .y  (logic_y)
  );

  alu_compare u_compare (
    .a_msb      (opnd_a[W-1]),
    .b_msb      (opnd_b[W-1]),
    .diff_msb   (arith_sum[W-1]),
    .carry_out  (arith_carry),
    .lt_signed  (lt_s),
    .lt_unsigned(lt_u)
  );

  always_comb begin
    unique case (op_sel)
      OP_ADD, OP_SUB:                  result = arith_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:   result = logic_y;
      OP_SLT:                          result = {{UPPER_W{1'b0}}, lt_s};
      OP_SLTU:                         result = {{UPPER_W{1'b0}}, lt_u};
      default:                         result = '0;
    endcase
  end

  assign zero_flag = ~|result;
  assign ovf_flag  = is_arith & arith_ovf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   op_sel,
  input logic [W-1:0] result,
  input logic         zero_flag,
  input logic         ovf_flag
);
  always_comb begin
    if (op_sel >= 4'd2) AST_NO_OVERFLOW: assert (!ovf_flag); // R7
    if (op_sel >= 4'd8) AST_UNUSED_CODE: assert (result == '0 && zero_flag); // R8
    if (op_sel == 4'd6 || op_sel == 4'd7) AST_CMP_UPPER: assert (result[W-1:1] == '0); // R4
    if (op_sel == 4'd7 && opnd_a == opnd_b) AST_SLTU_EQUAL: assert (result == '0); // R5
    if (op_sel == 4'd1) AST_SUB_ZERO: assert (zero_flag == (opnd_a == opnd_b)); // R6
    if (op_sel == 4'd0 && opnd_b == '0) AST_ADD_IDENT: assert (result == opnd_a); // R1
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_alu_core_chk (
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .op_sel   (op_sel),
  .result   (result),
  .zero_flag(zero_flag),
  .ovf_flag (ovf_flag)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] a32, b32, r32;
  logic [3:0]  op32;
  logic        z32, v32;
  logic [3:0]  a4, b4, r4;
  logic [3:0]  op4;
  logic        z4, v4;

  alu_core #(.W(32)) u_alu_core (
    .opnd_a(a32), .opnd_b(b32), .op_sel(op32),
    .result(r32), .zero_flag(z32), .ovf_flag(v32)
  );

  alu_core #(.W(4)) u_alu_core_w4 (
    .opnd_a(a4), .opnd_b(b4), .op_sel(op4),
    .result(r4), .zero_flag(z4), .ovf_flag(v4)
  );

  function automatic string req_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4, 5: return "R3";
      6: return "R4";
      7: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic void model(input int w, input longint a, input longint b, input int op,
                                output longint r, output bit z, output bit v);
    longint m = (64'sd1 <<< w) - 1;
    longint half = 64'sd1 <<< (w - 1);
    longint sa = (a >= half) ? a - (m + 1) : a;
    longint sb = (b >= half) ? b - (m + 1) : b;
    longint t;
    v = 1'b0;
    case (op)
      0: begin t = sa + sb; r = (a + b) & m; v = (t >= half) || (t < -half); end
      1: begin t = sa - sb; r = (a - b) & m; v = (t >= half) || (t < -half); end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = ~(a | b) & m;
      6: r = (sa < sb) ? 1 : 0;
      7: r = (a < b) ? 1 : 0;
      default: r = 0;
    endcase
    z = (r == 0);
  endfunction

  task automatic check4(input int a, input int b, input int op);
    longint er; bit ez, ev;
    a4 = a[3:0]; b4 = b[3:0]; op4 = op[3:0];
    #2;
    model(4, longint'(a), longint'(b), op, er, ez, ev);
    total++;
    if (longint'(r4) != er || z4 != ez || v4 != ev) begin
      bad++;
      $display("FAIL %s/R6/R7 w4 op=%0d a=%0d b=%0d: got r=%0d z=%0b v=%0b exp r=%0d z=%0b v=%0b",
               req_of(op), op, a, b, r4, z4, v4, er, ez, ev);
    end
  endtask

  task automatic check32(input logic [31:0] a, input logic [31:0] b, input int op);
    longint er; bit ez, ev;
    a32 = a; b32 = b; op32 = op[3:0];
    #2;
    model(32, longint'(a), longint'(b), op, er, ez, ev);
    total++;
    if (longint'(r32) != er || z32 != ez || v32 != ev) begin
      bad++;
      $display("FAIL %s/R6/R7 w32 op=%0d a=%h b=%h: got r=%h z=%0b v=%0b exp r=%h z=%0b v=%0b",
               req_of(op), op, a, b, r32, z32, v32, er, ez, ev);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        bad++;
        total++;
        $display("FAIL watchdog: got cycle %0d exp below %0d", cyc, WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] pats [8];
    a32 = '0; b32 = '0; op32 = '0;
    a4 = '0; b4 = '0; op4 = '0;
    @(negedge clk);
    // reset-free block: all-zero inputs give zero result and flags (R1, R6)
    check32(32'h0, 32'h0, 0);

    // exhaustive 4-bit sweep: R1..R8
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          check4(a, b, op);

    // R1: base plus negative sign-extended offset
    check32(32'h0000_1000, 32'hFFFF_FFF8, 0);
    // R7: extreme signed values
    check32(32'h7FFF_FFFF, 32'h0000_0001, 0);
    check32(32'h8000_0000, 32'h0000_0001, 1);
    // R4: compare where the difference overflows
    check32(32'h8000_0000, 32'h7FFF_FFFF, 6);
    check32(32'h7FFF_FFFF, 32'h8000_0000, 6);
    // R5
    check32(32'h7FFF_FFFF, 32'h8000_0000, 7);
    // R6: branch equality via subtract
    check32(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1);

    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0000;
    pats[3] = 32'h7FFF_FFFF; pats[4] = 32'h0000_0001; pats[5] = 32'hAAAA_5555;
    pats[6] = 32'h1234_5678; pats[7] = 32'hFFFF_FFFE;
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          check32(pats[i], pats[j], op);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule